// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings a single switchable power domain up or down in a safe order. A request names a target state, on or off. While the sequence runs the block reports busy. It ends either with a one-cycle done pulse or with a one-cycle timeout pulse. A timeout also sets an error flag that stays set until reset.

Going down, the block first walks the QoS snapshot strobes. It then raises the interconnect idle request and waits for the acknowledge, then for the idle status, and only then opens the power switch and waits for the status to show the domain off. Going up, it runs the same steps in the reverse order and ends by walking the QoS restore strobes.

Each wait step has a cycle budget that is set by a parameter. Build parameters select domain variants: a domain may have no idle handshake, no power switch, or no power-status bit. A domain without a power-status bit is judged to be on when it is not idle. The contents of the QoS registers belong to the surrounding logic. The block only produces the strobe, the port index and the register index for each save or restore step.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, busy, done, timeout, errSticky, idleReq, pwrOff and qosStrobe are all 0.
- R2: A request whose target already matches the domain state gives done in the cycle after acceptance, with no QoS strobe and no change on idleReq or pwrOff.
- R3: Power-down order: all save strobes, then idleReq rises, then, after the acknowledge and the idle status are both seen high, pwrOff rises; done follows once the power status reads 1.
- R4: Power-up order: pwrOff falls; once the power status reads 0, idleReq falls; once the acknowledge and the idle status are both seen low, the restore strobes run; then done.
- R5: The acknowledge wait compares ackIn with the direction of the move: 1 when entering idle, 0 when leaving idle.
- R6: pwrOffIn is 1 for a domain that is off and 0 for a powered one. With HAS_STATUS=0 the domain counts as on exactly when idleIn is 0.
- R7: With HAS_REQ=0, idleReq never rises and the handshake steps are skipped. With HAS_PWR=0, pwrOff never rises and the switch steps are skipped.
- R8: A wait step aborts if its condition has not been seen within TIMEOUT_CYCLES cycles of entering the step. timeout then pulses exactly TIMEOUT_CYCLES cycles after the step began, with no done, and busy drops in the next cycle. A condition first seen in the last cycle of the budget still lets the sequence continue.
- R9: errSticky goes high in the cycle after a timeout pulse and stays high until reset, through later successful requests.
- R10: A save or restore walk gives NUM_QOS*5 consecutive qosStrobe cycles, port-major. Within a port, qosReg steps 0 priority, 1 mode, 2 bandwidth, 3 saturation, 4 extended control. qosRestore is 0 for a save and 1 for a restore.
- R11: A request raised while busy is 1 is dropped: the running sequence keeps its timing and end state, and only one done pulse appears.
- R12: A request is accepted when reqValid is 1 and busy is 0. busy is 1 from the next cycle through the done or timeout cycle, and 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqOn | input | 1 | Target state: 1 on, 0 off |
| ackIn | input | 1 | Interconnect idle acknowledge |
| idleIn | input | 1 | Interconnect idle status |
| pwrOffIn | input | 1 | Power status, 1 = domain off |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse on an aborted wait |
| errSticky | output | 1 | Set by a timeout, cleared by reset |
| idleReq | output | 1 | Idle request to the interconnect |
| pwrOff | output | 1 | Power switch control, 1 = open the switch |
| qosStrobe | output | 1 | One QoS save or restore step this cycle |
| qosRestore | output | 1 | 0 = save step, 1 = restore step |
| qosPort | output | PortW | QoS port index of the step |
| qosReg | output | 3 | QoS register index of the step (0 to 4) |

## Verification
A wrong state transition or a miscounted wait appears at the ports as a shift in the done cycle. Every success latency is a closed form of the stimulus delays, so the bench compares each one to the exact cycle. A sequencer that skips a step or reorders one makes idleReq or pwrOff move before its gating status has been seen, and this is detectable at that edge. A wrong QoS counter shows up on the first strobe whose port or register index is out of order. A timeout counter that is off by one moves the timeout pulse by a cycle, or turns the boundary-delay case from a success into an abort.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_QSAVE,
    ST_REQ,
    ST_IDLEWAIT,
    ST_PDOWN,
    ST_PUP,
    ST_REL,
    ST_ACTWAIT,
    ST_QREST,
    ST_FIN,
    ST_FAIL
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic setIdleReq;
    logic clrIdleReq;
    logic setPwrOff;
    logic clrPwrOff;
    logic qosRun;
    logic qosRestore;
    logic setErr;
  } seqCtl_t;

  function automatic int portWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter bit HAS_REQ = 1'b1,
  parameter bit HAS_PWR = 1'b1,
  parameter int NUM_QOS = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqOn,
  input  logic    isOn,
  input  logic    ackIn,
  input  logic    idleIn,
  input  logic    waitExpired,
  input  logic    qosLast,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    timeout
);

  localparam bit QosEn = (NUM_QOS > 0);

  seqState_t state, nextState;

  // step that follows the active-wait in the power-up order
  function automatic seqState_t afterActive();
    if (QosEn) return ST_QREST;
    return ST_FIN;
  endfunction

  function automatic seqState_t afterPowerUp();
    if (HAS_REQ) return ST_REL;
    return afterActive();
  endfunction

  function automatic seqState_t firstUp();
    if (HAS_PWR) return ST_PUP;
    return afterPowerUp();
  endfunction

  function automatic seqState_t afterIdle();
    if (HAS_PWR) return ST_PDOWN;
    return ST_FIN;
  endfunction

  function automatic seqState_t afterSave();
    if (HAS_REQ) return ST_REQ;
    return afterIdle();
  endfunction

  function automatic seqState_t firstDown();
    if (QosEn) return ST_QSAVE;
    return afterSave();
  endfunction

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:
        if (reqValid) begin
          if (isOn == reqOn) nextState = ST_FIN;
          else if (reqOn)    nextState = firstUp();
          else               nextState = firstDown();
        end
      ST_QSAVE:    if (qosLast) nextState = afterSave();
      ST_REQ:      if (ackIn) nextState = ST_IDLEWAIT;
                   else if (waitExpired) nextState = ST_FAIL;
      ST_IDLEWAIT: if (idleIn) nextState = afterIdle();
                   else if (waitExpired) nextState = ST_FAIL;
      ST_PDOWN:    if (!isOn) nextState = ST_FIN;
                   else if (waitExpired) nextState = ST_FAIL;
      ST_PUP:      if (isOn) nextState = afterPowerUp();
                   else if (waitExpired) nextState = ST_FAIL;
      ST_REL:      if (!ackIn) nextState = ST_ACTWAIT;
                   else if (waitExpired) nextState = ST_FAIL;
      ST_ACTWAIT:  if (!idleIn) nextState = afterActive();
                   else if (waitExpired) nextState = ST_FAIL;
      ST_QREST:    if (qosLast) nextState = ST_FIN;
      ST_FIN:      nextState = ST_IDLE;
      ST_FAIL:     nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.cntClr     = (nextState != state);
    ctl.setIdleReq = (nextState == ST_REQ)   && (state != ST_REQ);
    ctl.clrIdleReq = (nextState == ST_REL)   && (state != ST_REL);
    ctl.setPwrOff  = (nextState == ST_PDOWN) && (state != ST_PDOWN);
    ctl.clrPwrOff  = (nextState == ST_PUP)   && (state != ST_PUP);
    ctl.qosRun     = (state == ST_QSAVE) || (state == ST_QREST);
    ctl.qosRestore = (state == ST_QREST);
    ctl.setErr     = (state == ST_FAIL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign timeout = (state == ST_FAIL);

endmodule

// File: rtl/pds_datapath.sv
module pds_datapath
  import pds_pkg::*;
#(
  parameter int NUM_QOS        = 2,
  parameter int TIMEOUT_CYCLES = 250000,
  localparam int PortW         = portWidth(NUM_QOS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  output logic             idleReq,
  output logic             pwrOff,
  output logic             errSticky,
  output logic             qosStrobe,
  output logic             qosRestore,
  output logic [PortW-1:0] qosPort,
  output logic [2:0]       qosReg,
  output logic             waitExpired,
  output logic             qosLast
);

  localparam int CntW         = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [2:0] LastReg = 3'd4;

  logic [CntW-1:0] waitCnt;

  // wait-step budget counter, restarted on every state change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      waitCnt <= '0;
    else if (ctl.cntClr)                            waitCnt <= '0;
    else if (waitCnt != CntW'(TIMEOUT_CYCLES - 1))  waitCnt <= waitCnt + 1'b1;
  end

  assign waitExpired = (waitCnt == CntW'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleReq   <= 1'b0;
      pwrOff    <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      if (ctl.setIdleReq)      idleReq <= 1'b1;
      else if (ctl.clrIdleReq) idleReq <= 1'b0;
      if (ctl.setPwrOff)       pwrOff <= 1'b1;
      else if (ctl.clrPwrOff)  pwrOff <= 1'b0;
      if (ctl.setErr)          errSticky <= 1'b1;
    end
  end

  assign qosStrobe  = ctl.qosRun;
  assign qosRestore = ctl.qosRestore;

  generate
    if (NUM_QOS > 0) begin : gQos
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          qosPort <= '0;
          qosReg  <= '0;
        end else if (!ctl.qosRun) begin
          qosPort <= '0;
          qosReg  <= '0;
        end else if (qosReg == LastReg) begin
          qosReg  <= '0;
          qosPort <= qosPort + 1'b1;
        end else begin
          qosReg  <= qosReg + 3'd1;
        end
      end
      assign qosLast = ctl.qosRun && (qosReg == LastReg) &&
                       (qosPort == PortW'(NUM_QOS - 1));
    end else begin : gNoQos
      assign qosPort = '0;
      assign qosReg  = '0;
      assign qosLast = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter bit HAS_REQ        = 1'b1,
  parameter bit HAS_PWR        = 1'b1,
  parameter bit HAS_STATUS     = 1'b1,
  parameter int NUM_QOS        = 2,
  parameter int TIMEOUT_CYCLES = 250000,
  localparam int PortW         = portWidth(NUM_QOS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqOn,
  input  logic             ackIn,
  input  logic             idleIn,
  input  logic             pwrOffIn,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             errSticky,
  output logic             idleReq,
  output logic             pwrOff,
  output logic             qosStrobe,
  output logic             qosRestore,
  output logic [PortW-1:0] qosPort,
  output logic [2:0]       qosReg
);

  seqCtl_t ctl;
  logic    isOn;
  logic    waitExpired;
  logic    qosLast;

  generate
    if (HAS_STATUS) begin : gStatus
      assign isOn = !pwrOffIn;
    end else begin : gIdleOnly
      assign isOn = !idleIn;
    end
  endgenerate

  pds_ctrl #(
    .HAS_REQ (HAS_REQ),
    .HAS_PWR (HAS_PWR),
    .NUM_QOS (NUM_QOS)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqOn       (reqOn),
    .isOn        (isOn),
    .ackIn       (ackIn),
    .idleIn      (idleIn),
    .waitExpired (waitExpired),
    .qosLast     (qosLast),
    .ctl         (ctl),
    .busy        (busy),
    .done        (done),
    .timeout     (timeout)
  );

  pds_datapath #(
    .NUM_QOS        (NUM_QOS),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .idleReq     (idleReq),
    .pwrOff      (pwrOff),
    .errSticky   (errSticky),
    .qosStrobe   (qosStrobe),
    .qosRestore  (qosRestore),
    .qosPort     (qosPort),
    .qosReg      (qosReg),
    .waitExpired (waitExpired),
    .qosLast     (qosLast)
  );

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter bit HAS_REQ    = 1'b1,
  parameter bit HAS_PWR    = 1'b1,
  parameter bit HAS_STATUS = 1'b1,
  parameter int PortW      = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             ackIn,
  input logic             idleIn,
  input logic             pwrOffIn,
  input logic             busy,
  input logic             done,
  input logic             timeout,
  input logic             errSticky,
  input logic             idleReq,
  input logic             pwrOff,
  input logic             qosStrobe,
  input logic [PortW-1:0] qosPort,
  input logic [2:0]       qosReg
);

  AST_DONE_NOT_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout)); // R8
  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |-> busy); // R12
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy); // R12
  AST_SWITCH_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_REQ && $rose(pwrOff)) |-> (idleReq && idleIn && ackIn)); // R3
  AST_RELEASE_AFTER_POWER: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_STATUS && $fell(idleReq)) |-> (!pwrOff && !pwrOffIn)); // R4
  AST_NO_IDLE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_REQ |-> !idleReq); // R7
  AST_NO_POWER_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_PWR |-> !pwrOff); // R7
  AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> (errSticky && !busy)); // R9
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R9
  AST_QOS_REG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    qosStrobe |-> (qosReg <= 3'd4)); // R10
  AST_QOS_REG_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (qosStrobe && $past(qosStrobe) && ($past(qosReg) != 3'd4)) |->
      (qosReg == 3'($past(qosReg) + 3'd1)) && $stable(qosPort)); // R10

endmodule

bind pwr_domain_seq pds_checker #(
  .HAS_REQ    (HAS_REQ),
  .HAS_PWR    (HAS_PWR),
  .HAS_STATUS (HAS_STATUS),
  .PortW      (PortW)
) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .ackIn     (ackIn),
  .idleIn    (idleIn),
  .pwrOffIn  (pwrOffIn),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .errSticky (errSticky),
  .idleReq   (idleReq),
  .pwrOff    (pwrOff),
  .qosStrobe (qosStrobe),
  .qosPort   (qosPort),
  .qosReg    (qosReg)
);

// File: tb/tb_pwr_domain_seq.sv
`timescale 1ns/1ps

// Behavioural stand-in for the interconnect and the power switch.
module pds_domain_model (
  input  logic clk,
  input  logic rstN,
  input  logic idleReq,
  input  logic pwrOff,
  input  int   dAck,
  input  int   dIdle,
  input  int   dPwr,
  input  logic holdAck,
  input  logic holdPwr,
  output logic ack,
  output logic idle,
  output logic pwrSt
);
  int cA, cI, cP;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ack <= 0; idle <= 0; pwrSt <= 0; cA <= 0; cI <= 0; cP <= 0;
    end else begin
      if (ack != idleReq && !holdAck) begin
        if (cA >= dAck) begin ack <= idleReq; cA <= 0; end else cA <= cA + 1;
      end else cA <= 0;
      if (idle != idleReq) begin
        if (cI >= dIdle) begin idle <= idleReq; cI <= 0; end else cI <= cI + 1;
      end else cI <= 0;
      if (pwrSt != pwrOff && !holdPwr) begin
        if (cP >= dPwr) begin pwrSt <= pwrOff; cP <= 0; end else cP <= cP + 1;
      end else cP <= 0;
    end
  end
endmodule

module tb_pwr_domain_seq;
  localparam int NQ    = 2;
  localparam int LIMIT = 20;
  localparam int QN    = NQ * 5;

  logic clk = 0;
  logic rstN = 0;
  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  // main instance: all features
  logic reqValid = 0, reqOn = 0;
  logic ack, idle, pwrSt;
  logic busy, done, timeout, errSticky, idleReq, pwrOff, qosStrobe, qosRestore;
  logic [0:0] qosPort;
  logic [2:0] qosReg;
  int dA = 0, dI = 0, dP = 0;
  logic holdAck = 0, holdPwr = 0;

  pwr_domain_seq #(.NUM_QOS(NQ), .TIMEOUT_CYCLES(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOn(reqOn),
    .ackIn(ack), .idleIn(idle), .pwrOffIn(pwrSt),
    .busy(busy), .done(done), .timeout(timeout), .errSticky(errSticky),
    .idleReq(idleReq), .pwrOff(pwrOff), .qosStrobe(qosStrobe),
    .qosRestore(qosRestore), .qosPort(qosPort), .qosReg(qosReg));

  pds_domain_model m1 (.clk(clk), .rstN(rstN), .idleReq(idleReq), .pwrOff(pwrOff),
    .dAck(dA), .dIdle(dI), .dPwr(dP), .holdAck(holdAck), .holdPwr(holdPwr),
    .ack(ack), .idle(idle), .pwrSt(pwrSt));

  // variant B: no status bit, no power switch; variant C: no idle handshake
  logic reqB = 0, reqBOn = 0;
  logic ack2, idle2, pwrSt2, busy2, done2, to2, err2, idleReq2, pwrOff2, qs2, qr2;
  logic [0:0] qp2; logic [2:0] qg2;
  logic ack3, idle3, pwrSt3, busy3, done3, to3, err3, idleReq3, pwrOff3, qs3, qr3;
  logic [0:0] qp3; logic [2:0] qg3;
  int one = 1;
  logic lo = 0;

  pwr_domain_seq #(.HAS_PWR(1'b0), .HAS_STATUS(1'b0), .NUM_QOS(1), .TIMEOUT_CYCLES(LIMIT)) dutB (
    .clk(clk), .rstN(rstN), .reqValid(reqB), .reqOn(reqBOn),
    .ackIn(ack2), .idleIn(idle2), .pwrOffIn(pwrSt2),
    .busy(busy2), .done(done2), .timeout(to2), .errSticky(err2),
    .idleReq(idleReq2), .pwrOff(pwrOff2), .qosStrobe(qs2),
    .qosRestore(qr2), .qosPort(qp2), .qosReg(qg2));
  pds_domain_model m2 (.clk(clk), .rstN(rstN), .idleReq(idleReq2), .pwrOff(pwrOff2),
    .dAck(one), .dIdle(one), .dPwr(one), .holdAck(lo), .holdPwr(lo),
    .ack(ack2), .idle(idle2), .pwrSt(pwrSt2));

  pwr_domain_seq #(.HAS_REQ(1'b0), .NUM_QOS(1), .TIMEOUT_CYCLES(LIMIT)) dutC (
    .clk(clk), .rstN(rstN), .reqValid(reqB), .reqOn(reqBOn),
    .ackIn(ack3), .idleIn(idle3), .pwrOffIn(pwrSt3),
    .busy(busy3), .done(done3), .timeout(to3), .errSticky(err3),
    .idleReq(idleReq3), .pwrOff(pwrOff3), .qosStrobe(qs3),
    .qosRestore(qr3), .qosPort(qp3), .qosReg(qg3));
  pds_domain_model m3 (.clk(clk), .rstN(rstN), .idleReq(idleReq3), .pwrOff(pwrOff3),
    .dAck(one), .dIdle(one), .dPwr(one), .holdAck(lo), .holdPwr(lo),
    .ack(ack3), .idle(idle3), .pwrSt(pwrSt3));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // event marks (negedge cycle numbers) for the main instance
  int tQosFirst, tQosLast, tReqRise, tReqFall, tAckRise, tAckFall;
  int tIdleRise, tIdleFall, tPwrRise, tPwrFall, tStRise, tStFall;
  int qosSeen, doneCnt, doneCnt2, doneCnt3;
  int expPort, expReg;
  bit expRestore;
  bit idleReq3Ever, pwrOff2Ever;
  logic pIdleReq, pAck, pIdle, pPwrOff, pSt;

  task automatic clearMarks();
    tQosFirst = -1; tQosLast = -1; tReqRise = -1; tReqFall = -1; tAckRise = -1;
    tAckFall = -1; tIdleRise = -1; tIdleFall = -1; tPwrRise = -1; tPwrFall = -1;
    tStRise = -1; tStFall = -1; qosSeen = 0; doneCnt = 0; expPort = 0; expReg = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (qosStrobe) begin
        chk(qosPort == expPort[0:0] && qosReg == expReg[2:0] && qosRestore == expRestore,
            "R10 qos step", int'(qosRestore) * 64 + int'(qosPort) * 8 + int'(qosReg),
            int'(expRestore) * 64 + expPort * 8 + expReg);
        if (tQosFirst < 0) tQosFirst = cyc;
        tQosLast = cyc; qosSeen++;
        if (expReg == 4) begin expReg = 0; expPort++; end else expReg++;
      end
      if (idleReq && !pIdleReq && tReqRise < 0) tReqRise = cyc;
      if (!idleReq && pIdleReq && tReqFall < 0) tReqFall = cyc;
      if (ack && !pAck && tAckRise < 0) tAckRise = cyc;
      if (!ack && pAck && tAckFall < 0) tAckFall = cyc;
      if (idle && !pIdle && tIdleRise < 0) tIdleRise = cyc;
      if (!idle && pIdle && tIdleFall < 0) tIdleFall = cyc;
      if (pwrOff && !pPwrOff && tPwrRise < 0) tPwrRise = cyc;
      if (!pwrOff && pPwrOff && tPwrFall < 0) tPwrFall = cyc;
      if (pwrSt && !pSt && tStRise < 0) tStRise = cyc;
      if (!pwrSt && pSt && tStFall < 0) tStFall = cyc;
      if (done) doneCnt++;
      if (done2) doneCnt2++;
      if (done3) doneCnt3++;
      if (idleReq3) idleReq3Ever = 1;
      if (pwrOff2) pwrOff2Ever = 1;
    end
    pIdleReq = idleReq; pAck = ack; pIdle = idle; pPwrOff = pwrOff; pSt = pwrSt;
  end

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 0; reqValid = 0; reqB = 0; holdAck = 0; holdPwr = 0;
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    clearMarks(); doneCnt2 = 0; doneCnt3 = 0; idleReq3Ever = 0; pwrOff2Ever = 0;
  endtask

  // issue a request on the main instance; lat = cycles until done/timeout
  task automatic runOp(input bit on, input int glitchAt, output int lat, output int c0);
    clearMarks(); expRestore = on;
    @(negedge clk); #1;
    reqValid = 1; reqOn = on; c0 = cyc; lat = -1;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk); #1;
      reqValid = (k == glitchAt);
      reqOn = (k == glitchAt) ? !on : on;
      if (done || timeout) begin lat = k; break; end
    end
    reqValid = 0;
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int offLat(input int a, input int i, input int p);
    return imax(QN + 3 + a, QN + 2 + i) + 3 + p;
  endfunction

  function automatic int onLat(input int a, input int i, input int p);
    return imax(5 + p + a, 4 + p + i) + QN + 1;
  endfunction

  task automatic checkOff(input int lat, input string tag);
    chk(lat == offLat(dA, dI, dP), {tag, " R3 off latency"}, lat, offLat(dA, dI, dP));
    chk(qosSeen == QN, "R10 save count", qosSeen, QN);
    chk(tQosLast < tReqRise, "R3 save before idle request", tQosLast, tReqRise);
    chk(tPwrRise > tAckRise && tPwrRise > tIdleRise, "R5 switch after ack=1 and idle",
        tPwrRise, imax(tAckRise, tIdleRise) + 1);
    chk(idleReq && pwrOff && !timeout, "R3 end state", {idleReq, pwrOff, timeout}, 3'b110);
  endtask

  task automatic checkOn(input int lat, input string tag);
    chk(lat == onLat(dA, dI, dP), {tag, " R4 on latency"}, lat, onLat(dA, dI, dP));
    chk(qosSeen == QN, "R10 restore count", qosSeen, QN);
    chk(tReqFall > tStFall, "R6 release after status=0", tReqFall, tStFall + 1);
    chk(tQosFirst > tAckFall && tQosFirst > tIdleFall, "R5 restore after ack=0 and idle=0",
        tQosFirst, imax(tAckFall, tIdleFall) + 1);
    chk(!idleReq && !pwrOff, "R4 end state", {idleReq, pwrOff}, 0);
  endtask

  task automatic runB(input bit on, output int lat);
    int d2, d3;
    d2 = doneCnt2; d3 = doneCnt3;
    @(negedge clk); #1;
    reqB = 1; reqBOn = on; lat = -1;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk); #1;
      reqB = 0;
      if (doneCnt2 > d2 && doneCnt3 > d3) begin lat = k; break; end
    end
  endtask

  initial begin
    int lat, c0;
    doReset();
    @(negedge clk); #1;
    // R1 reset state
    chk(!busy && !done && !timeout && !errSticky && !idleReq && !pwrOff && !qosStrobe,
        "R1 reset outputs", {busy, done, timeout, errSticky, idleReq, pwrOff, qosStrobe}, 0);

    // R2 already on
    runOp(1'b1, 0, lat, c0);
    chk(lat == 1 && done, "R2 already-on latency", lat, 1);
    chk(qosSeen == 0 && tReqRise < 0 && tPwrFall < 0, "R2 no action", qosSeen, 0);
    @(negedge clk); #1;
    chk(!busy, "R12 busy drops after done", busy, 0);

    // sweep of stimulus delays
    for (int a = 0; a < 3; a++)
      for (int i = 0; i < 3; i++)
        for (int p = 0; p < 3; p++) begin
          dA = (a == 2) ? 4 : a; dI = (i == 2) ? 4 : i; dP = (p == 2) ? 4 : p;
          runOp(1'b0, 0, lat, c0); checkOff(lat, "sweep");
          runOp(1'b1, 0, lat, c0); checkOn(lat, "sweep");
        end

    // R11 requests during busy are dropped
    dA = 1; dI = 2; dP = 1;
    runOp(1'b0, 3, lat, c0); checkOff(lat, "R11");
    @(negedge clk); #1;
    chk(doneCnt == 1 && !busy, "R11 single done after off", doneCnt, 1);
    runOp(1'b1, 5, lat, c0); checkOn(lat, "R11");
    @(negedge clk); #1;
    chk(doneCnt == 1 && !busy, "R11 single done after on", doneCnt, 1);

    // R8 boundary: ack seen in the last budget cycle still succeeds
    dA = LIMIT - 2; dI = 0; dP = 0;
    runOp(1'b0, 0, lat, c0); checkOff(lat, "R8 boundary");
    runOp(1'b1, 0, lat, c0);
    chk(lat == onLat(dA, dI, dP) && !errSticky, "R8 boundary on", lat, onLat(dA, dI, dP));

    // R8 just past the boundary: timeout
    dA = LIMIT - 1;
    runOp(1'b0, 0, lat, c0);
    chk(lat == QN + LIMIT + 1 && timeout, "R8 ack timeout cycle", lat, QN + LIMIT + 1);
    chk(doneCnt == 0, "R8 no done on timeout", doneCnt, 0);
    @(negedge clk); #1;
    chk(errSticky && !busy, "R9 error set, idle again", {errSticky, busy}, 2'b10);
    repeat (30) @(negedge clk); #1;
    chk(errSticky, "R9 error held", errSticky, 1);
    doReset();
    @(negedge clk); #1;
    chk(!errSticky && !idleReq, "R1 reset clears error", errSticky, 0);

    // R8 timeout on the power step; R9 survives a later good request
    dA = 0; dI = 0; dP = 0; holdPwr = 1;
    runOp(1'b0, 0, lat, c0);
    chk(lat == QN + 3 + LIMIT + 1, "R8 power timeout cycle", lat, QN + 3 + LIMIT + 1);
    holdPwr = 0;
    repeat (5) @(negedge clk); #1;
    runOp(1'b1, 0, lat, c0);
    chk(done && pwrSt == 1'b0, "R6 status 1 read as off, restart works", lat, -2);
    chk(errSticky, "R9 error kept after success", errSticky, 1);

    // variants: no status/no switch (B), no handshake (C)
    doReset();
    runB(1'b0, lat);
    chk(lat > 0 && idleReq2 && !pwrOff2Ever, "R7 no switch: off done, pwrOff stays 0",
        pwrOff2Ever, 0);
    chk(!idleReq3Ever && pwrOff3, "R7 no handshake: idleReq stays 0", idleReq3Ever, 0);
    runB(1'b0, lat);
    chk(lat == 1, "R6 idle-only domain reads off when idle", lat, 1);
    runB(1'b1, lat);
    chk(lat > 1 && !idleReq2 && !pwrOff3 && !idleReq3Ever, "R7 variants back on",
        {idleReq2, pwrOff3}, 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule